// File: doc/BRIEF.md
# Bus Data-Phase Handshake Monitor

A passive observer for a parallel bus whose control lines are active low: a framing line from the initiator, an initiator-ready line, a target-ready line, a target-stop line and a target-select line. The monitor drives nothing onto the bus. It samples the lines on every rising clock edge and follows each transaction from its start to its last data phase. On the way it reports completed data phases, actual data transfers and wait cycles, and it raises a sticky flag whenever either side breaks a handshake rule.

Two commitment rules are enforced, one for each side. Once the target has asserted target-ready or stop in a data phase, its select, ready and stop lines must not change until that phase completes. Once the initiator has asserted initiator-ready, it must keep the line asserted until the phase completes. The monitor also checks that the framing line is never released before initiator-ready is asserted, and that select and stop stay asserted until the transaction ends. Every output is registered, so it reflects the edge one clock earlier.

Top module: `bus_handshake_monitor`

## Requirements
- R1: `phase_done` is high for exactly one cycle after each edge where a transaction is active, `irdy_n` is 0, and at least one of `trdy_n` or `stop_n` is 0.
- R2: `xfer` is high for one cycle after a completing edge only if both `irdy_n` and `trdy_n` were 0 on that edge. A phase that completes through `stop_n` alone gives `phase_done` without `xfer`.
- R3: Suppose that on an earlier edge of the current data phase the target had `trdy_n` or `stop_n` at 0 and the phase did not complete. A later edge of that phase on which `trdy_n`, `stop_n` or `devsel_n` differs from its value on the edge before sets `viol_tgt`.
- R4: Suppose that on an earlier edge of the current data phase `irdy_n` was 0 and the phase did not complete. An edge of that phase with `irdy_n` at 1 sets `viol_ini`.
- R5: During a transaction, an edge on which `frame_n` has gone from 0 to 1 while `irdy_n` is 1 sets `viol_frame`.
- R6: During a transaction, `devsel_n` or `stop_n` returning to 1 after it was 0 on an earlier edge of that transaction sets `viol_hold`.
- R7: Each violation flag stays at 1 once set and is cleared only by the synchronous active-high `rst`.
- R8: `phase_cnt` counts completed data phases since reset and saturates at 65535.
- R9: `wait_cnt` counts edges inside a transaction, after its address edge, on which `irdy_n` and `trdy_n` are both 1.
- R10: A transaction starts only on an edge where `frame_n` is 0 and the edge before had `frame_n` and `irdy_n` both at 1. It ends after the completing edge on which `frame_n` is 1. A handshake seen outside a transaction is ignored.
- R11: Commitment tracking restarts after each completed phase, so a ready line that changes on the edge after a completion is not a violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge sampling |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Initiator framing line, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| stop_n | input | 1 | Target stop request, active low |
| devsel_n | input | 1 | Target select acknowledge, active low |
| phase_done | output | 1 | One-cycle pulse per completed data phase |
| xfer | output | 1 | One-cycle pulse per data transfer |
| viol_tgt | output | 1 | Sticky: target changed lines after committing |
| viol_ini | output | 1 | Sticky: initiator withdrew ready |
| viol_frame | output | 1 | Sticky: framing released before initiator ready |
| viol_hold | output | 1 | Sticky: select or stop released inside a transaction |
| phase_cnt | output | 16 | Saturating count of completed phases |
| wait_cnt | output | 16 | Saturating count of wait cycles |

## Verification
The assertions watch every cycle for three things. A completion or transfer pulse must never appear unless the matching handshake was on the bus one edge earlier. The violation flags must never fall outside reset. The phase counter must move only together with a completion pulse. The bench scenarios are needed for the rest: the timing of transaction start and end, the restart of commitment tracking after each completion, the exact edge on which each violation fires, and counter saturation. Each of these depends on a sequence of bus states that only directed stimulus can set up.

// File: rtl/bus_handshake_monitor.sv
module bus_handshake_monitor #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          trdy_n,
  input  logic          stop_n,
  input  logic          devsel_n,
  output logic          phase_done,
  output logic          xfer,
  output logic          viol_tgt,
  output logic          viol_ini,
  output logic          viol_frame,
  output logic          viol_hold,
  output logic [CW-1:0] phase_cnt,
  output logic [CW-1:0] wait_cnt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic in_txn, tgt_hold, ini_hold, sel_seen, stp_seen;
  logic p_frame, p_irdy, p_trdy, p_stop, p_devsel;

  wire start    = !in_txn && !frame_n && p_frame && p_irdy;
  wire active   = in_txn || start;
  wire done     = active && !irdy_n && !(trdy_n && stop_n);
  wire last     = done && frame_n;
  wire tgt_bad  = tgt_hold && ((trdy_n != p_trdy) || (stop_n != p_stop) || (devsel_n != p_devsel));
  wire ini_bad  = ini_hold && irdy_n;
  wire frm_bad  = in_txn && frame_n && !p_frame && irdy_n;
  wire hold_bad = in_txn && ((sel_seen && devsel_n) || (stp_seen && stop_n));
  wire waiting  = in_txn && irdy_n && trdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_txn <= 1'b0; tgt_hold <= 1'b0; ini_hold <= 1'b0;
      sel_seen <= 1'b0; stp_seen <= 1'b0;
      p_frame <= 1'b1; p_irdy <= 1'b1; p_trdy <= 1'b1; p_stop <= 1'b1; p_devsel <= 1'b1;
      phase_done <= 1'b0; xfer <= 1'b0;
      viol_tgt <= 1'b0; viol_ini <= 1'b0; viol_frame <= 1'b0; viol_hold <= 1'b0;
      phase_cnt <= '0; wait_cnt <= '0;
    end else begin
      p_frame <= frame_n; p_irdy <= irdy_n; p_trdy <= trdy_n;
      p_stop <= stop_n; p_devsel <= devsel_n;

      if (last) in_txn <= 1'b0;
      else if (start) in_txn <= 1'b1;

      if (done || !active) tgt_hold <= 1'b0;
      else if (!trdy_n || !stop_n) tgt_hold <= 1'b1;

      if (done || !active) ini_hold <= 1'b0;
      else if (!irdy_n) ini_hold <= 1'b1;

      if (last || !active) sel_seen <= 1'b0;
      else if (!devsel_n) sel_seen <= 1'b1;

      if (last || !active) stp_seen <= 1'b0;
      else if (!stop_n) stp_seen <= 1'b1;

      phase_done <= done;
      xfer       <= done && !trdy_n;

      viol_tgt   <= viol_tgt   | tgt_bad;
      viol_ini   <= viol_ini   | ini_bad;
      viol_frame <= viol_frame | frm_bad;
      viol_hold  <= viol_hold  | hold_bad;

      if (done && phase_cnt != CMAX) phase_cnt <= phase_cnt + 1'b1;
      if (waiting && wait_cnt != CMAX) wait_cnt <= wait_cnt + 1'b1;
    end
  end

  a_r1_done_needs_handshake: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> $past(!irdy_n && !(trdy_n && stop_n)));

  a_r2_xfer_needs_both_ready: assert property (@(posedge clk) disable iff (rst)
    xfer |-> $past(!irdy_n && !trdy_n));

  a_r4_ini_flag_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(viol_ini) |-> $past(irdy_n));

  a_r7_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    ($past({viol_tgt, viol_ini, viol_frame, viol_hold}) &
     ~{viol_tgt, viol_ini, viol_frame, viol_hold}) == 4'b0);

  a_r8_count_moves_with_done: assert property (@(posedge clk) disable iff (rst)
    (phase_cnt != $past(phase_cnt)) |-> phase_done);
endmodule

// File: tb/bus_handshake_monitor_tb.sv
module bus_handshake_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1, stop_n = 1'b1, devsel_n = 1'b1;
  logic phase_done, xfer, viol_tgt, viol_ini, viol_frame, viol_hold;
  logic [15:0] phase_cnt, wait_cnt;
  int checks = 0, errors = 0;
  logic [1:0] expq[$];

  always #2 clk = ~clk;

  bus_handshake_monitor u_dut (
    .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .stop_n(stop_n), .devsel_n(devsel_n), .phase_done(phase_done), .xfer(xfer),
    .viol_tgt(viol_tgt), .viol_ini(viol_ini), .viol_frame(viol_frame),
    .viol_hold(viol_hold), .phase_cnt(phase_cnt), .wait_cnt(wait_cnt));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (expq.size() > 0) begin
      logic [1:0] e;
      e = expq.pop_front();
      chk("R1 phase_done", phase_done, e[1]);
      chk("R2 xfer", xfer, e[0]);
    end
  end

  task automatic drive(input logic f, input logic i, input logic t, input logic s,
                       input logic d, input logic epd, input logic exf);
    @(negedge clk);
    frame_n = f; irdy_n = i; trdy_n = t; stop_n = s; devsel_n = d;
    expq.push_back({epd, exf});
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1; devsel_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic flags(input string req, input logic [3:0] exp);
    chk(req, {viol_tgt, viol_ini, viol_frame, viol_hold}, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R7 reset phase_done", phase_done, 0);
    chk("R8 reset phase_cnt", phase_cnt, 0);
    chk("R9 reset wait_cnt", wait_cnt, 0);
    flags("R7 reset flags", 4'b0000);

    // single-phase write
    drive(0,1,1,1,1, 0,0);
    drive(1,0,0,1,0, 1,1);
    drive(1,1,1,1,1, 0,0);
    chk("R8 count one", phase_cnt, 1);
    flags("R10 clean single", 4'b0000);

    // burst with waits; R11 trdy released after completion
    drive(0,1,1,1,1, 0,0);
    drive(0,1,1,1,0, 0,0);
    drive(0,0,1,1,0, 0,0);
    drive(0,0,0,1,0, 1,1);
    drive(0,1,1,1,0, 0,0);
    drive(1,0,0,1,0, 1,1);
    drive(1,1,1,1,1, 0,0);
    chk("R9 wait count", wait_cnt, 2);
    chk("R8 count three", phase_cnt, 3);
    flags("R11 no violation after restart", 4'b0000);

    // disconnect via stop only: completion without transfer
    drive(0,1,1,1,1, 0,0);
    drive(0,0,1,0,0, 1,0);
    drive(1,0,1,0,0, 1,0);
    drive(1,1,1,1,1, 0,0);
    chk("R2 stop count", phase_cnt, 5);
    flags("R6 stop held", 4'b0000);

    // handshake outside a transaction is ignored
    drive(1,0,0,1,0, 0,0);
    drive(1,1,1,1,1, 0,0);
    chk("R10 ignored outside", phase_cnt, 5);

    // target violation
    drive(0,1,1,1,1, 0,0);
    drive(0,1,0,1,0, 0,0);
    drive(0,1,1,1,0, 0,0);
    flags("R3 target change", 4'b1000);
    drive(0,1,1,1,0, 0,0);
    drive(0,1,1,1,0, 0,0);
    chk("R7 sticky tgt", viol_tgt, 1);
    do_reset(); #1;
    flags("R7 cleared by reset", 4'b0000);

    // initiator violation
    drive(0,1,1,1,1, 0,0);
    drive(0,0,1,1,0, 0,0);
    drive(0,1,1,1,0, 0,0);
    flags("R4 initiator retract", 4'b0100);
    do_reset();

    // early frame release
    drive(0,1,1,1,1, 0,0);
    drive(1,1,1,1,1, 0,0);
    flags("R5 frame early", 4'b0010);
    do_reset();

    // select dropped inside transaction
    drive(0,1,1,1,1, 0,0);
    drive(0,1,1,1,0, 0,0);
    drive(0,1,1,1,1, 0,0);
    flags("R6 select dropped", 4'b0001);
    do_reset();

    // saturation of phase counter
    drive(0,1,1,1,1, 0,0);
    for (int k = 0; k < 65540; k++) drive(0,0,0,1,0, 1,1);
    chk("R8 saturation", phase_cnt, 16'hFFFF);
    flags("R8 no flags in long burst", 4'b0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule